// File: doc/BRIEF.md
# Two-Pattern Delay Test Sequencer

This block drives a chain of muxed scan flip-flops so that two-pattern delay tests can be applied to the logic the chain surrounds. Each test is started by one pulse on `start_i`. The block first shifts the first vector in with scan-enable high. It then performs a launch, which creates the second vector. One or more functional cycles follow, and the last of these captures the response. Finally the block shifts the response out serially with scan-enable high. The bits that enter the chain during this unload form the next load.

The launch is chosen per test. In shift-style launch, scan-enable stays high for one more shift, so the second vector is the first vector moved by one cell. In capture-style launch, scan-enable drops right after the load. The block then waits a programmable number of idle cycles with the clock enable low, and the launch edge loads the functional logic's response to the first vector. The combinational logic under test sits outside the block: it reads `chain_q_o` and returns `func_d_i`. Chain length, idle gap and activation count are sampled when the test starts.

Top module: `delay_test_seq`

## Requirements
- R1: After reset the phase is idle (code 0), scan-enable, clock enable and done are 0, and every chain cell is 0. The phase codes are: idle 0, shift 1, gap 2, launch 3, activate 4, capture 5.
- R2: The cycle after `start_i` is sampled in idle, the block spends L cycles in phase shift with scan-enable 1 and clock enable 1. L is the sampled chain length. Each enabled shift edge moves cell k-1 into cell k and loads `scan_in_i` into cell 0.
- R3: In shift-style launch (`los_mode_i`=1), the load is followed directly by one launch cycle with scan-enable 1 and clock enable 1. This cycle performs one more shift.
- R4: In shift-style launch the sampled idle count is ignored, and scan-enable is 0 in the cycle right after the launch cycle.
- R5: In capture-style launch, scan-enable is 0 from the end of the load onward. The load is followed by exactly the sampled idle count of gap cycles, which may be zero. During these cycles the clock enable is 0 and the chain holds its contents.
- R6: In capture-style launch, the launch cycle has scan-enable 0 and clock enable 1, so every cell loads `func_d_i`.
- R7: With A as the sampled activation count, where 0 is treated as 1, the launch is followed by A-1 activate cycles and then one capture cycle. All of these cycles are functional: scan-enable 0 and clock enable 1. Counts up to 15 are accepted.
- R8: After capture the block spends L cycles in phase shift with scan-enable 1. `scan_out_o` shows cell L-1, so the captured response leaves the chain from cell L-1 downward.
- R9: After the last unload cycle, the phase is idle and `done_o` is 1 for exactly one cycle.
- R10: A chain length of 0 is treated as 1, and a length above the chain size is treated as the chain size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts one test when the block is idle |
| los_mode_i | input | 1 | 1 selects shift-style launch, 0 selects capture-style launch |
| chain_len_i | input | LEN_W | Active chain length in cells |
| idle_cnt_i | input | IDLE_W | Gap cycles before a capture-style launch |
| act_cnt_i | input | ACT_W | Activation cycles, from the launch up to the capture |
| scan_in_i | input | 1 | Serial scan data into cell 0 |
| func_d_i | input | CHAIN_N | Functional logic response to the chain contents |
| chain_q_o | output | CHAIN_N | Chain contents, fed to the logic under test |
| scan_en_o | output | 1 | Scan-enable for all cells |
| clk_en_o | output | 1 | Clock enable for all cells |
| phase_o | output | 3 | Current phase code |
| scan_out_o | output | 1 | Serial data out from cell L-1 |
| done_o | output | 1 | One-cycle pulse after the final unload |

## Verification
The bench runs both launch styles against a rotate-and-mix function as the logic under test. It predicts every phase, every enable and every unloaded bit. A zero idle gap is exercised; a design that still entered the gap phase, or that counted one cycle too many, would shift the whole trace and corrupt the response. An activation count of 0 and counts of 11 and 15 are used; an off-by-one count changes how many times the function is applied, so the unloaded response would differ. Lengths of 0 and 12 test the clamp, where a wrong tap would unload the wrong cell. A nonzero idle count in shift-style launch must produce no gap cycles at all.

// File: rtl/dts_pkg.sv
`timescale 1ns/1ps
package dts_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SHIFT  = 3'd1,
    PH_GAP    = 3'd2,
    PH_LAUNCH = 3'd3,
    PH_ACT    = 3'd4,
    PH_CAPT   = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_GAP, ST_LAUNCH, ST_ACT, ST_CAPT, ST_UNLOAD
  } state_e;

  // Clamp a requested chain length into 1..n (R10)
  function automatic int unsigned eff_len(input int unsigned req, input int unsigned n);
    if (req == 0) return 1;
    if (req > n) return n;
    return req;
  endfunction

  // Activation count of zero behaves as one (R7)
  function automatic int unsigned eff_act(input int unsigned req);
    return (req == 0) ? 1 : req;
  endfunction

  function automatic phase_e phase_of(input state_e s);
    case (s)
      ST_LOAD, ST_UNLOAD: return PH_SHIFT;
      ST_GAP:             return PH_GAP;
      ST_LAUNCH:          return PH_LAUNCH;
      ST_ACT:             return PH_ACT;
      ST_CAPT:            return PH_CAPT;
      default:            return PH_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/dts_ctrl.sv
`timescale 1ns/1ps
module dts_ctrl
  import dts_pkg::*;
#(
  parameter int CHAIN_N = 8,
  parameter int LEN_W   = 4,
  parameter int IDLE_W  = 4,
  parameter int ACT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              los_mode_i,
  input  logic [LEN_W-1:0]  chain_len_i,
  input  logic [IDLE_W-1:0] idle_cnt_i,
  input  logic [ACT_W-1:0]  act_cnt_i,
  output state_e            state_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              scan_en_o,
  output logic              clk_en_o,
  output logic              done_o
);
  localparam int W1    = (LEN_W > IDLE_W) ? LEN_W : IDLE_W;
  localparam int CNT_W = (W1 > ACT_W) ? W1 : ACT_W;

  state_e            state;
  logic [CNT_W-1:0]  cnt;
  logic              los_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDLE_W-1:0] idle_q;
  logic [ACT_W-1:0]  act_q;
  logic              done_q;
  logic              cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      los_q  <= 1'b0;
      len_q  <= LEN_W'(1);
      idle_q <= '0;
      act_q  <= ACT_W'(1);
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          los_q  <= los_mode_i;
          len_q  <= LEN_W'(eff_len(32'(chain_len_i), CHAIN_N));
          idle_q <= idle_cnt_i;
          act_q  <= ACT_W'(eff_act(32'(act_cnt_i)));
          cnt    <= CNT_W'(eff_len(32'(chain_len_i), CHAIN_N) - 1);
          state  <= ST_LOAD;
        end
        ST_LOAD: if (cnt_zero) begin
          if (los_q || idle_q == '0) state <= ST_LAUNCH;
          else begin
            state <= ST_GAP;
            cnt   <= CNT_W'(idle_q) - CNT_W'(1);
          end
        end else cnt <= cnt - CNT_W'(1);
        ST_GAP: if (cnt_zero) state <= ST_LAUNCH;
                else cnt <= cnt - CNT_W'(1);
        ST_LAUNCH: if (act_q == ACT_W'(1)) state <= ST_CAPT;
          else begin
            state <= ST_ACT;
            cnt   <= CNT_W'(act_q) - CNT_W'(2);
          end
        ST_ACT: if (cnt_zero) state <= ST_CAPT;
                else cnt <= cnt - CNT_W'(1);
        ST_CAPT: begin
          state <= ST_UNLOAD;
          cnt   <= CNT_W'(len_q) - CNT_W'(1);
        end
        ST_UNLOAD: if (cnt_zero) begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
        end else cnt <= cnt - CNT_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scan_en_o = (state == ST_LOAD) || (state == ST_UNLOAD) ||
                ((state == ST_LAUNCH) && los_q);
    clk_en_o  = (state != ST_IDLE) && (state != ST_GAP);
  end

  assign state_o = state;
  assign len_o   = len_q;
  assign done_o  = done_q;
endmodule

// File: rtl/dts_chain.sv
`timescale 1ns/1ps
module dts_chain #(
  parameter int CHAIN_N = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en_i,
  input  logic               scan_en_i,
  input  logic               scan_in_i,
  input  logic [CHAIN_N-1:0] func_d_i,
  output logic [CHAIN_N-1:0] q_o
);
  logic [CHAIN_N-1:0] shift_src;

  assign shift_src[0] = scan_in_i;

  for (genvar k = 0; k < CHAIN_N; k++) begin : g_cell
    if (k > 0) begin : g_link
      assign shift_src[k] = q_o[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[k] <= 1'b0;
      else if (clk_en_i) q_o[k] <= scan_en_i ? shift_src[k] : func_d_i[k];
    end
  end
endmodule

// File: rtl/dts_tap.sv
`timescale 1ns/1ps
module dts_tap #(
  parameter int CHAIN_N = 8,
  parameter int LEN_W   = 4
) (
  input  logic [CHAIN_N-1:0] q_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               so_o
);
  localparam int IDX_W = (CHAIN_N > 1) ? $clog2(CHAIN_N) : 1;
  logic [IDX_W-1:0] idx;
  assign idx  = IDX_W'(len_i - LEN_W'(1));
  assign so_o = q_i[idx];
endmodule

// File: rtl/delay_test_seq.sv
`timescale 1ns/1ps
module delay_test_seq
  import dts_pkg::*;
#(
  parameter int CHAIN_N = 8,
  parameter int LEN_W   = $clog2(CHAIN_N + 1),
  parameter int IDLE_W  = 4,
  parameter int ACT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               los_mode_i,
  input  logic [LEN_W-1:0]   chain_len_i,
  input  logic [IDLE_W-1:0]  idle_cnt_i,
  input  logic [ACT_W-1:0]   act_cnt_i,
  input  logic               scan_in_i,
  input  logic [CHAIN_N-1:0] func_d_i,
  output logic [CHAIN_N-1:0] chain_q_o,
  output logic               scan_en_o,
  output logic               clk_en_o,
  output logic [2:0]         phase_o,
  output logic               scan_out_o,
  output logic               done_o
);
  state_e           state;
  logic [LEN_W-1:0] len_q;
  logic             se, ce;

  dts_ctrl #(.CHAIN_N(CHAIN_N), .LEN_W(LEN_W), .IDLE_W(IDLE_W), .ACT_W(ACT_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .los_mode_i(los_mode_i),
    .chain_len_i(chain_len_i), .idle_cnt_i(idle_cnt_i), .act_cnt_i(act_cnt_i),
    .state_o(state), .len_o(len_q), .scan_en_o(se), .clk_en_o(ce), .done_o(done_o)
  );

  dts_chain #(.CHAIN_N(CHAIN_N)) i_chain (
    .clk(clk), .rst_n(rst_n), .clk_en_i(ce), .scan_en_i(se),
    .scan_in_i(scan_in_i), .func_d_i(func_d_i), .q_o(chain_q_o)
  );

  dts_tap #(.CHAIN_N(CHAIN_N), .LEN_W(LEN_W)) i_tap (
    .q_i(chain_q_o), .len_i(len_q), .so_o(scan_out_o)
  );

  assign scan_en_o = se;
  assign clk_en_o  = ce;
  assign phase_o   = 3'(phase_of(state));
endmodule

// File: rtl/dts_checker.sv
`timescale 1ns/1ps
module dts_checker
  import dts_pkg::*;
#(
  parameter int CHAIN_N = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scan_in_i,
  input logic [CHAIN_N-1:0] chain_q_o,
  input logic               scan_en_o,
  input logic               clk_en_o,
  input logic [2:0]         phase_o,
  input logic               done_o
);
  AST_LOAD_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_SHIFT) |-> (scan_en_o && clk_en_o));                       // R2
  AST_SHIFT_LAUNCH_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_LAUNCH && scan_en_o) |=>
      (chain_q_o == $past({chain_q_o[CHAIN_N-2:0], scan_in_i})));              // R3
  AST_SE_DROPS_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_LAUNCH && scan_en_o) |=> !scan_en_o);                       // R4
  AST_GAP_HOLDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_GAP) |=> $stable(chain_q_o));                               // R5
  AST_GAP_SE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_GAP) |-> !scan_en_o);                                       // R5
  AST_FUNC_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_ACT || phase_o == PH_CAPT) |-> (!scan_en_o && clk_en_o));   // R7
  AST_CAPT_TO_UNLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_CAPT) |=> (phase_o == PH_SHIFT));                           // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                                       // R9
  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (phase_o == PH_IDLE && !clk_en_o));                             // R9
endmodule

bind delay_test_seq dts_checker #(.CHAIN_N(CHAIN_N)) i_dts_checker (
  .clk(clk), .rst_n(rst_n), .scan_in_i(scan_in_i), .chain_q_o(chain_q_o),
  .scan_en_o(scan_en_o), .clk_en_o(clk_en_o), .phase_o(phase_o), .done_o(done_o)
);

// File: tb/test_delay_test_seq.sv
`timescale 1ns/1ps
module test_delay_test_seq;
  import dts_pkg::*;

  localparam int   CN     = 8;
  localparam int   LW     = 4;
  localparam int   IW     = 4;
  localparam int   AW     = 4;
  localparam time  PERIOD = 10ns;
  localparam logic [CN-1:0] MIX = CN'(8'hA5);

  typedef struct {
    phase_e ph;
    bit se, ce, dn, chk, so, si;
    string tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, los = 1'b0, scan_in = 1'b0;
  logic [LW-1:0] clen = '0;
  logic [IW-1:0] idle = '0;
  logic [AW-1:0] act = '0;
  logic [CN-1:0] func_d, chain_q;
  logic se, ce, so, done;
  logic [2:0] phase;

  int  n_checks = 0, n_fail = 0;
  bit  mon_en = 1'b0;
  bit  finished = 1'b0;
  item_t exp_q[$];
  logic [CN-1:0] model = '0;

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [CN-1:0] fl(input logic [CN-1:0] x);
    return {x[CN-2:0], x[CN-1]} ^ MIX;
  endfunction

  assign func_d = fl(chain_q);

  delay_test_seq #(.CHAIN_N(CN), .LEN_W(LW), .IDLE_W(IW), .ACT_W(AW)) i_delay_test_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .los_mode_i(los),
    .chain_len_i(clen), .idle_cnt_i(idle), .act_cnt_i(act), .scan_in_i(scan_in),
    .func_d_i(func_d), .chain_q_o(chain_q), .scan_en_o(se), .clk_en_o(ce),
    .phase_o(phase), .scan_out_o(so), .done_o(done)
  );

  task automatic check(input string tag, input string what, input int actual, input int expect_v);
    n_checks++;
    if (actual != expect_v) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, actual, expect_v);
    end
  endtask

  task automatic push(input phase_e ph, input bit s, input bit c, input bit d,
                      input bit k, input bit o, input bit i, input string tag);
    item_t it;
    it.ph = ph; it.se = s; it.ce = c; it.dn = d; it.chk = k; it.so = o; it.si = i; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: pops one expected item per cycle, drives the serial bit for the next edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_en && exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        scan_in = it.si;
        check(it.tag, "phase", int'(phase), int'(it.ph));
        check(it.tag, "scan_en", int'(se), int'(it.se));
        check(it.tag, "clk_en", int'(ce), int'(it.ce));
        check(it.tag, "done", int'(done), int'(it.dn));
        if (it.chk) check(it.tag, "scan_out", int'(so), int'(it.so));
      end
    end
  end

  // Driver: builds the expected trace from the requirements, then starts the test
  task automatic run_test(input bit l_mode, input int len, input int gap, input int nact, input int seed);
    int L = (len == 0) ? 1 : ((len > CN) ? CN : len);
    int A = (nact == 0) ? 1 : nact;
    string utag = (L != len) ? "R10" : "R8";
    bit b;
    for (int k = 0; k < L; k++) begin
      b = 1'((seed >> k) & 1);
      push(PH_SHIFT, 1, 1, 0, 0, 0, b, "R2");
      model = {model[CN-2:0], b};
    end
    if (!l_mode) for (int g = 0; g < gap; g++) push(PH_GAP, 0, 0, 0, 0, 0, 0, "R5");
    b = 1'((seed >> 9) & 1);
    push(PH_LAUNCH, l_mode, 1, 0, 0, 0, b, l_mode ? "R3" : "R6");
    model = l_mode ? {model[CN-2:0], b} : fl(model);
    for (int k = 0; k < A - 1; k++) begin
      push(PH_ACT, 0, 1, 0, 0, 0, 0, (k == 0 && l_mode) ? "R4" : "R7");
      model = fl(model);
    end
    push(PH_CAPT, 0, 1, 0, 0, 0, 0, (A == 1 && l_mode) ? "R4" : "R7");
    model = fl(model);
    for (int k = 0; k < L; k++) begin
      b = 1'((seed >> (12 + k)) & 1);
      push(PH_SHIFT, 1, 1, 0, 1, model[L-1], b, utag);
      model = {model[CN-2:0], b};
    end
    push(PH_IDLE, 0, 0, 1, 0, 0, 0, "R9");
    push(PH_IDLE, 0, 0, 0, 0, 0, 0, "R9");
    @(negedge clk);
    los = l_mode; clen = LW'(len); idle = IW'(gap); act = AW'(nact); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mon_en = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_en = 1'b0;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "phase", int'(phase), 0);
    check("R1", "scan_en", int'(se), 0);
    check("R1", "clk_en", int'(ce), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "chain", int'(chain_q), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "phase idle after release", int'(phase), 0);

    run_test(1'b1, 8, 5, 1, 32'h0003_A5C3);   // R4: idle count ignored in shift launch
    run_test(1'b0, 8, 0, 1, 32'h0005_3C96);   // R5: zero gap
    run_test(1'b0, 5, 3, 3, 32'h0009_1E2D);
    run_test(1'b1, 3, 0, 0, 32'h000E_7B41);   // R7: zero activation count
    run_test(1'b0, 8, 2, 11, 32'h0002_D0F7);  // R7: eleven activation cycles
    run_test(1'b1, 0, 1, 2, 32'h000B_6E19);   // R10: length 0
    run_test(1'b0, 12, 1, 15, 32'h0007_4AB3); // R10: length above chain size
    run_test(1'b1, 6, 0, 4, 32'h000C_9251);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule